// File: doc/BRIEF.md
# Eight-Operation Byte ALU with Status Flags

This block is the arithmetic and logic stage of a small byte-wide processor. A 4-bit operation code selects one of eight functions on two 8-bit operands:

- addition and subtraction
- bitwise AND, OR and XOR
- a one-place left or right shift
- the low byte of an unsigned product

Each result comes with four status outputs. Carry and signed overflow are defined per operation. Zero and negative are read from the final result byte. Division is handled by a separate iterative unit, and the flag register sits in the surrounding processor.

The operation logic is purely combinational. Its outputs are captured in a single output register, so every result appears one clock after its operands are presented. The processor drives a new operation every cycle and reads the result and flags on the following cycle. Operation codes 8 to 15 are not arithmetic operations for this block: the first operand passes through unchanged.

Top module: `alu8_core`

## Requirements
- R1: Result and all four flags are updated on every rising clock edge from the opcode and operands sampled at that edge, so they reflect the inputs presented exactly one clock earlier.
- R2: Opcode 0 (add) yields (a+b) mod 256, with carry 1 exactly when a+b exceeds 255.
- R3: For opcode 0, overflow is bit 7 of (a XOR result) AND (b XOR result).
- R4: Opcode 1 (subtract) yields (a-b) mod 256, with carry 1 exactly when a >= b as unsigned values (carry means no borrow).
- R5: For opcode 1, overflow is bit 7 of (a XOR b) AND (a XOR result).
- R6: Opcodes 2, 3 and 4 yield a AND b, a OR b and a XOR b respectively, with carry and overflow 0.
- R7: Opcode 5 shifts a left by one and opcode 6 shifts a right by one. The vacated bit is filled with 0, b is ignored, and carry and overflow are 0.
- R8: Opcode 7 yields the low 8 bits of the unsigned product a*b, with carry and overflow 0.
- R9: For every opcode, zero is 1 exactly when the 8-bit result is 0, and negative equals bit 7 of the result.
- R10: Opcodes 8 through 15 return a unchanged, with carry and overflow 0.
- R11: While reset is low, result, carry, overflow and negative are 0 and zero is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand (the only operand used by shifts and pass-through) |
| b_i | input | 8 | Second operand |
| result_o | output | 8 | Registered result byte |
| carry_o | output | 1 | Registered carry (for subtract: no-borrow) |
| overflow_o | output | 1 | Registered signed overflow |
| zero_o | output | 1 | Registered flag, 1 when the result is zero |
| negative_o | output | 1 | Registered copy of result bit 7 |

## Verification
The bound checker compares, on every cycle, the registered result and flags against the operands of the previous cycle. It covers:

- the add and subtract sums
- the no-borrow carry
- both overflow formulas
- the truncated product
- the zero fill of both shifts
- pass-through for unlisted opcodes
- consistency of zero and negative with the result byte

Some behaviour only the bench's scenarios can show. These are the reset values, and that the second operand has no effect on shifts and pass-through. Boundary operands are also exercised there: all-ones, sign-boundary values, equal operands for subtract, and products that wrap to 0 or 1.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_ADD = 4'h0;
    localparam logic [OP_W-1:0] OP_SUB = 4'h1;
    localparam logic [OP_W-1:0] OP_AND = 4'h2;
    localparam logic [OP_W-1:0] OP_OR  = 4'h3;
    localparam logic [OP_W-1:0] OP_XOR = 4'h4;
    localparam logic [OP_W-1:0] OP_SHL = 4'h5;
    localparam logic [OP_W-1:0] OP_SHR = 4'h6;
    localparam logic [OP_W-1:0] OP_MUL = 4'h7;

    typedef struct packed {
        logic carry;
        logic ovf;
        logic zero;
        logic neg;
    } alu_flags_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   chain;

    assign b_eff    = sub_i ? ~b_i : b_i;
    assign chain[0] = sub_i;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_fa
            logic p;
            assign p           = a_i[gi] ^ b_eff[gi];
            assign sum_o[gi]   = p ^ chain[gi];
            assign chain[gi+1] = (a_i[gi] & b_eff[gi]) | (p & chain[gi]);
        end
    endgenerate

    assign cout_o = chain[WIDTH];

    always_comb begin
        if (sub_i) begin
            ovf_o = (a_i[MSB] ^ b_i[MSB]) & (a_i[MSB] ^ sum_o[MSB]);
        end else begin
            ovf_o = (a_i[MSB] ^ sum_o[MSB]) & (b_i[MSB] ^ sum_o[MSB]);
        end
    end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [OP_W-1:0]  op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o
);
    always_comb begin
        case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_SHL:  res_o = {a_i[WIDTH-2:0], 1'b0};
            OP_SHR:  res_o = {1'b0, a_i[WIDTH-1:1]};
            default: res_o = a_i;
        endcase
    end
endmodule

// File: rtl/alu8_mul.sv
module alu8_mul #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] prod_o
);
    logic [WIDTH-1:0] acc [WIDTH+1];

    assign acc[0] = '0;

    genvar gr;
    generate
        for (gr = 0; gr < WIDTH; gr++) begin : g_row
            logic [WIDTH-1:0] pp;
            assign pp          = {WIDTH{b_i[gr]}} & (a_i << gr);
            assign acc[gr + 1] = acc[gr] + pp;
        end
    endgenerate

    assign prod_o = acc[WIDTH];
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             overflow_o,
    output logic             zero_o,
    output logic             negative_o
);
    typedef struct packed {
        logic [WIDTH-1:0] res;
        alu_flags_t       flg;
    } alu_out_t;

    alu_out_t out_d, out_q;

    logic [WIDTH-1:0] as_sum, bit_res, mul_prod;
    logic             as_cout, as_ovf, is_sub;

    assign is_sub = (op_i == OP_SUB);

    alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i    (a_i),
        .b_i    (b_i),
        .sub_i  (is_sub),
        .sum_o  (as_sum),
        .cout_o (as_cout),
        .ovf_o  (as_ovf)
    );

    alu8_bitops #(.WIDTH(WIDTH)) u_bitops (
        .op_i  (op_i),
        .a_i   (a_i),
        .b_i   (b_i),
        .res_o (bit_res)
    );

    alu8_mul #(.WIDTH(WIDTH)) u_mul (
        .a_i    (a_i),
        .b_i    (b_i),
        .prod_o (mul_prod)
    );

    always_comb begin
        out_d           = '0;
        out_d.flg.carry = 1'b0;
        out_d.flg.ovf   = 1'b0;
        case (op_i)
            OP_ADD, OP_SUB: begin
                out_d.res       = as_sum;
                out_d.flg.carry = as_cout;
                out_d.flg.ovf   = as_ovf;
            end
            OP_MUL:  out_d.res = mul_prod;
            default: out_d.res = bit_res;
        endcase
        out_d.flg.zero = (out_d.res == '0);
        out_d.flg.neg  = out_d.res[WIDTH-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q          <= '0;
            out_q.flg.zero <= 1'b1;
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o   = out_q.res;
    assign carry_o    = out_q.flg.carry;
    assign overflow_o = out_q.flg.ovf;
    assign zero_o     = out_q.flg.zero;
    assign negative_o = out_q.flg.neg;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       op_i,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [WIDTH-1:0] result_o,
    input logic             carry_o,
    input logic             overflow_o,
    input logic             zero_o,
    input logic             negative_o
);
    localparam int MSB = WIDTH - 1;

    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2
    p_add_sum_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(op_i) == 4'h0 |-> {carry_o, result_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)}));

    // R3
    p_add_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(op_i) == 4'h0 |-> overflow_o ==
            (($past(a_i[MSB]) ^ result_o[MSB]) & ($past(b_i[MSB]) ^ result_o[MSB])));

    // R4
    p_sub_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(op_i) == 4'h1 |-> (result_o == WIDTH'($past(a_i) - $past(b_i)))
            && (carry_o == ($past(a_i) >= $past(b_i))));

    // R5
    p_sub_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(op_i) == 4'h1 |-> overflow_o ==
            (($past(a_i[MSB]) ^ $past(b_i[MSB])) & ($past(a_i[MSB]) ^ result_o[MSB])));

    // R6
    p_logic_flags_r6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(op_i) >= 4'h2 && $past(op_i) <= 4'h4) |-> !carry_o && !overflow_o);

    // R7
    p_shl_fill_r7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(op_i) == 4'h5 |-> !result_o[0] && !carry_o && !overflow_o);

    p_shr_fill_r7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(op_i) == 4'h6 |-> !result_o[MSB] && !carry_o && !overflow_o);

    // R8
    p_mul_low_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(op_i) == 4'h7 |-> result_o == WIDTH'($past(a_i) * $past(b_i)) && !carry_o && !overflow_o);

    // R9
    p_zn_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o == (result_o == '0)) && (negative_o == result_o[MSB]));

    // R10
    p_pass_r10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(op_i[3]) |-> result_o == $past(a_i) && !carry_o && !overflow_o);
endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu8_core_bench.sv
module alu8_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] a_i = '0, b_i = '0;
    logic [7:0] result_o;
    logic       carry_o, overflow_o, zero_o, negative_o;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    alu8_core u_alu8_core (.*);

    function automatic logic [10:0] model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
        logic [8:0]  s;
        logic [15:0] p;
        logic [7:0]  r;
        logic        c, v;
        c = 1'b0; v = 1'b0;
        case (op)
            4'h0: begin s = a + b; r = s[7:0]; c = s[8]; v = ((a ^ r) & (b ^ r)) >> 7; end
            4'h1: begin r = a - b; c = (a >= b); v = ((a ^ b) & (a ^ r)) >> 7; end
            4'h2: r = a & b;
            4'h3: r = a | b;
            4'h4: r = a ^ b;
            4'h5: r = {a[6:0], 1'b0};
            4'h6: r = {1'b0, a[7:1]};
            4'h7: begin p = a * b; r = p[7:0]; end
            default: r = a;
        endcase
        return {r, c, v, 1'b0};
    endfunction

    function automatic string tag_res(input logic [3:0] op);
        case (op)
            4'h0: return "R2";
            4'h1: return "R4";
            4'h2, 4'h3, 4'h4: return "R6";
            4'h5, 4'h6: return "R7";
            4'h7: return "R8";
            default: return "R10";
        endcase
    endfunction

    function automatic string tag_ovf(input logic [3:0] op);
        case (op)
            4'h0: return "R3";
            4'h1: return "R5";
            default: return tag_res(op);
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // R1: inputs driven at one falling edge, outputs checked at the next one
    task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
        logic [10:0] e;
        @(negedge clk);
        op_i = op; a_i = a; b_i = b;
        e = model(op, a, b);
        @(negedge clk);
        check(tag_res(op), "result", result_o, e[10:3]);
        check(tag_res(op), "carry", carry_o, e[2]);
        check(tag_ovf(op), "overflow", overflow_o, e[1]);
        check("R9", "zero", zero_o, (e[10:3] == 8'h00));
        check("R9", "negative", negative_o, e[10]);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd5150);
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", "result", result_o, 0);
        check("R11", "carry", carry_o, 0);
        check("R11", "overflow", overflow_o, 0);
        check("R11", "zero", zero_o, 1);
        check("R11", "negative", negative_o, 0);
        rst_n = 1'b1;
        // directed corners
        apply(4'h0, 8'hFF, 8'h01);  // R2 wrap to zero with carry
        apply(4'h0, 8'h7F, 8'h01);  // R3 positive overflow
        apply(4'h0, 8'h80, 8'h80);  // R3 negative overflow, carry
        apply(4'h1, 8'h10, 8'h20);  // R4 borrow -> carry 0
        apply(4'h1, 8'h42, 8'h42);  // R4 equal -> carry 1, zero
        apply(4'h1, 8'h80, 8'h01);  // R5 overflow
        apply(4'h5, 8'h81, 8'hFF);  // R7 b ignored
        apply(4'h6, 8'h81, 8'h00);  // R7
        apply(4'h7, 8'h10, 8'h10);  // R8 wraps to zero
        apply(4'h7, 8'hFF, 8'hFF);  // R8 low byte 01
        apply(4'h8, 8'h5A, 8'hFF);  // R10
        apply(4'hF, 8'hC3, 8'h3C);  // R10
        // R1: back-to-back random operations
        for (int i = 0; i < 800; i++) begin
            apply(4'($urandom_range(0, 15)), 8'($urandom()), 8'($urandom()));
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule